// File: doc/BRIEF.md
# Read-Address Sequence Write-Protect Guard

This block keeps a software write-protect flag for a non-volatile memory controller. It does not decode written data to change the flag. Instead it watches the address of every read access. Seven reads in a row at a fixed list of addresses change the flag. The first six addresses of that list are shared by both outcomes, and the seventh address selects the result: one address clears the flag and another sets it. The flag output gates the command state machine, so program and erase commands are refused while it is set.

Each access arrives as a single-cycle synchronous strobe, together with a 16-bit address, and no data bus is involved. Address bits above the low 13 are not compared. A read that does not continue the sequence restarts the matcher. A write strobe discards any partial progress. The number of steps matched so far is output so that the command logic can see that an unlock is under way. Reset leaves the memory protected.

Top module: `rdseq_guard`

## Requirements
- R1: After reset, `prot_flag` is 1 and `seq_step` is 0.
- R2: `seq_step` gives the number of consecutive matched reads, from 0 to 6. A read at the next expected address raises it by one in the cycle after the strobe. The first six expected addresses are 1823h, 1820h, 1822h, 0418h, 041Bh and 0419h, in that order.
- R3: A read that does not match the expected address restarts the matcher. `seq_step` becomes 1 if that read's address is 1823h, and 0 otherwise.
- R4: When `seq_step` is 6, a read at 041Ah clears `prot_flag` to 0 and returns `seq_step` to 0.
- R5: When `seq_step` is 6, a read at 040Ah sets `prot_flag` to 1 and returns `seq_step` to 0.
- R6: Only address bits [12:0] are compared. The values of bits [15:13] have no effect on matching.
- R7: A write strobe returns `seq_step` to 0 and leaves `prot_flag` unchanged. If a write strobe and a read strobe arrive in the same cycle, the write takes priority.
- R8: In a cycle with no strobe, both outputs hold their values.
- R9: Completing a sequence whose result equals the current flag value leaves the flag unchanged and returns `seq_step` to 0.
- R10: `prot_flag` changes only in the cycle after a read that completes a seven-read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_pulse | input | 1 | One-cycle strobe for each read access |
| wr_pulse | input | 1 | One-cycle strobe for each write access |
| addr | input | 16 | Address of the access |
| prot_flag | output | 1 | 1 while software write protection is active |
| seq_step | output | 3 | Number of sequence reads matched so far |

## Verification
The hardest case to reach is a read at the first address arriving while the matcher is deep in a sequence, in particular as a wrong seventh read. That read must restart the count at one rather than zero, and a sequence completed right after it must still take effect. The bench builds this by issuing six correct reads, then 1823h, and then the remaining six addresses. A second hard case is a completion read that coincides with a write strobe. Both strobes are driven in the same cycle, and the flag is observed afterwards.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int unsigned SEQ_LEN = 7;
  localparam int unsigned KEYS    = SEQ_LEN + 1;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN);
  localparam int unsigned LAST    = SEQ_LEN - 1;

  typedef logic [STEP_W-1:0] step_t;

  // Key list: indices 0..LAST-1 are the shared prefix,
  // LAST is the clearing finish, LAST+1 the setting finish.
  function automatic logic [15:0] key_addr(input int unsigned idx);
    case (idx)
      0:       key_addr = 16'h1823;
      1:       key_addr = 16'h1820;
      2:       key_addr = 16'h1822;
      3:       key_addr = 16'h0418;
      4:       key_addr = 16'h041B;
      5:       key_addr = 16'h0419;
      6:       key_addr = 16'h041A;
      default: key_addr = 16'h040A;
    endcase
  endfunction
endpackage

// File: rtl/rdseq_rst_sync.sv
module rdseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rdseq_match.sv
module rdseq_match
  import rdseq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HI_IGNORE = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  step_t             step,
  output logic              hit_step,
  output logic              hit_first,
  output logic              hit_clear,
  output logic              hit_set
);
  localparam int unsigned CMP_W = ADDR_W - HI_IGNORE;
  localparam logic [ADDR_W-1:0] CMP_MASK = {{HI_IGNORE{1'b0}}, {CMP_W{1'b1}}};

  logic [KEYS-1:0] key_hit;

  for (genvar g = 0; g < KEYS; g++) begin : g_key
    localparam logic [ADDR_W-1:0] KEY = ADDR_W'(key_addr(g));
    assign key_hit[g] = ((addr ^ KEY) & CMP_MASK) == '0;
  end

  always_comb begin
    hit_step = 1'b0;
    for (int i = 0; i < LAST; i++) begin
      if (step == step_t'(i)) hit_step = key_hit[i];
    end
  end

  assign hit_first = key_hit[0];
  assign hit_clear = key_hit[LAST];
  assign hit_set   = key_hit[LAST+1];
endmodule

// File: rtl/rdseq_track.sv
module rdseq_track
  import rdseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_pulse,
  input  logic  wr_pulse,
  input  logic  hit_step,
  input  logic  hit_first,
  input  logic  hit_clear,
  input  logic  hit_set,
  output step_t step,
  output logic  done_clear,
  output logic  done_set
);
  step_t step_q, step_d;
  logic  step_en;

  always_comb begin
    step_d     = step_q;
    done_clear = 1'b0;
    done_set   = 1'b0;
    if (wr_pulse) begin
      step_d = '0;
    end else if (rd_pulse) begin
      if (step_q == step_t'(LAST)) begin
        if (hit_clear) begin
          done_clear = 1'b1;
          step_d     = '0;
        end else if (hit_set) begin
          done_set = 1'b1;
          step_d   = '0;
        end else begin
          step_d = hit_first ? step_t'(1) : '0;
        end
      end else if (hit_step) begin
        step_d = step_q + step_t'(1);
      end else begin
        step_d = hit_first ? step_t'(1) : '0;
      end
    end
  end

  assign step_en = rd_pulse | wr_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/rdseq_flag.sv
module rdseq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic done_clear,
  input  logic done_set,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  assign flag_en = done_clear | done_set;

  always_comb begin
    flag_d = flag_q;
    if (done_clear)    flag_d = 1'b0;
    else if (done_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rdseq_guard.sv
module rdseq_guard
  import rdseq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HI_IGNORE = 3,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pulse,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_flag,
  output logic [STEP_W-1:0] seq_step
);
  logic  rst_n_int;
  step_t step;
  logic  hit_step, hit_first, hit_clear, hit_set;
  logic  done_clear, done_set;

  rdseq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  rdseq_match #(.ADDR_W(ADDR_W), .HI_IGNORE(HI_IGNORE)) u_match (
    .addr(addr), .step(step),
    .hit_step(hit_step), .hit_first(hit_first),
    .hit_clear(hit_clear), .hit_set(hit_set)
  );

  rdseq_track u_track (
    .clk(clk), .rst_n(rst_n_int),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .hit_step(hit_step), .hit_first(hit_first),
    .hit_clear(hit_clear), .hit_set(hit_set),
    .step(step), .done_clear(done_clear), .done_set(done_set)
  );

  rdseq_flag u_flag (
    .clk(clk), .rst_n(rst_n_int),
    .done_clear(done_clear), .done_set(done_set), .flag(prot_flag)
  );

  assign seq_step = step;
endmodule

// File: rtl/rdseq_guard_chk.sv
module rdseq_guard_chk
  import rdseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_pulse,
  input logic              wr_pulse,
  input logic [ADDR_W-1:0] addr,
  input logic              prot_flag,
  input logic [STEP_W-1:0] seq_step
);
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_step <= STEP_W'(LAST)); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !wr_pulse && seq_step != STEP_W'(LAST))
      |=> (seq_step <= STEP_W'(1)) || (seq_step == $past(seq_step) + STEP_W'(1))); // R3

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> (seq_step == '0) && $stable(prot_flag)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pulse && !wr_pulse) |=> $stable(seq_step) && $stable(prot_flag)); // R8

  AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_flag) |-> ($past(rd_pulse) && $past(seq_step) == STEP_W'(LAST))); // R10

  AST_FINISH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && seq_step == STEP_W'(LAST)) |=> seq_step <= STEP_W'(1)); // R4
endmodule

bind rdseq_guard rdseq_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
  .addr(addr), .prot_flag(prot_flag), .seq_step(seq_step)
);

// File: tb/rdseq_guard_tb.sv
module rdseq_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_pulse = 1'b0;
  logic        wr_pulse = 1'b0;
  logic [15:0] addr = '0;
  logic        prot_flag;
  logic [2:0]  seq_step;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rdseq_guard u_dut (
    .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .addr(addr), .prot_flag(prot_flag), .seq_step(seq_step)
  );

  logic [15:0] pre [6] = '{16'h1823, 16'h1820, 16'h1822, 16'h0418, 16'h041B, 16'h0419};
  localparam logic [15:0] FIN_CLR = 16'h041A;
  localparam logic [15:0] FIN_SET = 16'h040A;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); rd_pulse = 1'b1; addr = a;
    @(negedge clk); rd_pulse = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a);
    @(negedge clk); wr_pulse = 1'b1; addr = a;
    @(negedge clk); wr_pulse = 1'b0;
  endtask

  task automatic prefix(input logic [15:0] hi);
    for (int i = 0; i < 6; i++) rd(pre[i] | hi);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 flag", prot_flag, 1);
    check("R1 step", seq_step, 0);
  endtask

  task automatic t_progress();
    for (int i = 0; i < 6; i++) begin
      rd(pre[i]);
      check("R2 step", seq_step, i + 1);
    end
    repeat (3) @(negedge clk);
    check("R8 hold step", seq_step, 6);
    check("R8 hold flag", prot_flag, 1);
    rd(FIN_CLR);
    check("R4 flag cleared", prot_flag, 0);
    check("R4 step", seq_step, 0);
  endtask

  task automatic t_lock();
    prefix(16'h0000);
    rd(FIN_SET);
    check("R5 flag set", prot_flag, 1);
    check("R5 step", seq_step, 0);
  endtask

  task automatic t_redundant();
    prefix(16'h0000);
    rd(FIN_SET);
    check("R9 set while set", prot_flag, 1);
    check("R9 step", seq_step, 0);
  endtask

  task automatic t_break();
    rd(pre[0]); rd(pre[1]); rd(pre[2]);
    rd(16'h0100);
    check("R3 mismatch restart", seq_step, 0);
    rd(pre[0]); rd(pre[1]);
    rd(16'h1823);
    check("R3 mismatch at first addr", seq_step, 1);
    prefix(16'h0000);
    rd(16'h1823);
    check("R3 wrong seventh at first addr", seq_step, 1);
    check("R10 no flag change", prot_flag, 1);
    for (int i = 1; i < 6; i++) rd(pre[i]);
    rd(FIN_CLR);
    check("R3 resumed sequence clears", prot_flag, 0);
    prefix(16'h0000);
    rd(16'h041B);
    check("R3 bad seventh", seq_step, 0);
    check("R10 bad seventh flag", prot_flag, 0);
  endtask

  task automatic t_high_bits();
    prefix(16'hE000);
    check("R6 step with high bits", seq_step, 6);
    rd(FIN_SET | 16'hA000);
    check("R6 flag set via aliased addr", prot_flag, 1);
    rd(16'h1823 | 16'h4000);
    rd(16'h1820 | 16'h2000);
    check("R6 mixed high bits", seq_step, 2);
    wr(16'h0000);
  endtask

  task automatic t_write();
    rd(pre[0]); rd(pre[1]); rd(pre[2]); rd(pre[3]);
    wr(16'h1822);
    check("R7 write clears step", seq_step, 0);
    check("R7 flag unchanged", prot_flag, 1);
    prefix(16'h0000);
    @(negedge clk); rd_pulse = 1'b1; wr_pulse = 1'b1; addr = FIN_CLR;
    @(negedge clk); rd_pulse = 1'b0; wr_pulse = 1'b0;
    check("R7 write wins flag", prot_flag, 1);
    check("R7 write wins step", seq_step, 0);
    prefix(16'h0000);
    rd(FIN_CLR);
    check("R4 clear after write", prot_flag, 0);
    prefix(16'h0000);
    rd(FIN_CLR);
    check("R9 clear while clear", prot_flag, 0);
    check("R9 step idle", seq_step, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_progress();
    t_lock();
    t_redundant();
    t_break();
    t_high_bits();
    t_write();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule